// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Packing

This block buffers outgoing audio samples between a 32-bit write port and a codec-side link. Each bus word is turned into one or two 20-bit samples, left-justified, and stored in a small circular buffer. In normal mode a word carries one sample of 12, 16, 18 or 20 bits. In compact mode a word carries two 16-bit-container samples; the low half is stored first. Compact mode only applies to 12 and 16-bit sizes.

Samples leave as left/right pairs on a valid/ready port, at most one pair per clock. A burst of draining starts once transmit is enabled, slot 3 or slot 4 is selected, and the buffer holds at least half its depth. The burst then keeps going while the codec accepts pairs and at least two samples remain. The block keeps four status flags (empty, half-empty, full, underrun) for a separate interrupt block. These flags change on write and drain events and are not pure functions of the fill level.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset st_empty and st_half are 1, st_full and st_underrun are 0, the level is zero and cdc_valid is 0.
- R2: The cfg_size code selects 0 = 16-bit, 1 = 18-bit, 2 = 20-bit and 3 = 12-bit samples. A normal-mode word is shifted left by 4, 2, 0 or 8 bits for these codes and truncated to 20 bits before it is stored.
- R3: With cfg_compact = 1 and cfg_size 0 or 3, a word stores wr_data[15:0] and then wr_data[31:16]. Each half is shifted left by 8 bits for code 3 or by 4 bits for code 0, and truncated to 20 bits. With cfg_size 1 or 2, cfg_compact is ignored and the word is stored as in normal mode.
- R4: A normal write is dropped when the level equals DEPTH. A compact write is dropped unless level+2 < DEPTH. A dropped write stores nothing.
- R5: On any write cycle, the level after the cycle decides the flags. A nonzero level clears st_empty and st_underrun. A level >= DEPTH/2 clears st_half. A level >= DEPTH sets st_full. st_full and st_empty are never both 1.
- R6: cdc_valid is asserted only when cfg_enable = 1, cfg_slot_sel[0] (slot 3) or cfg_slot_sel[1] (slot 4) is 1, and at least two samples are held. A burst starts only at level >= DEPTH/2. cdc_left is the oldest stored sample and cdc_right is the next.
- R7: A pair moves when cdc_valid and cdc_ready are both 1. While draining, one pair moves per clock until fewer than two samples remain. If the codec refuses a pair (valid with ready low), the burst ends. A new burst then needs level >= DEPTH/2 again.
- R8: On a drain cycle st_full clears. st_half sets if the resulting level <= DEPTH/2. st_empty and st_underrun set if the resulting level is zero. st_underrun is only ever 1 while st_empty is 1.
- R9: A write and a drain in the same cycle update the level by the number of samples pushed minus two, and the sample order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe for the data port |
| wr_data | input | 32 | Bus write word |
| cfg_enable | input | 1 | Transmit enable |
| cfg_compact | input | 1 | Two samples per word (12/16-bit only) |
| cfg_size | input | 2 | Sample size code (see R2) |
| cfg_slot_sel | input | 2 | Bit 0 selects slot 3, bit 1 selects slot 4 |
| cdc_ready | input | 1 | Codec can take a pair |
| cdc_valid | output | 1 | A pair is offered |
| cdc_left | output | 20 | Left sample, left-justified |
| cdc_right | output | 20 | Right sample, left-justified |
| st_empty | output | 1 | Buffer empty flag |
| st_half | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |

## Verification
A corrupted pointer or a mis-packed write shows up as a wrong cdc_left or cdc_right on the very pair that carries the sample. The bench sees this in the cycle that pair is offered, because it compares every transferred pair against its own queue of expected samples. A wrong level shows up as a flag that changes one write or one drain too early or too late, or as cdc_valid rising or falling at the wrong cycle. The bench checks these right after each write and each drain step. A dropped write that was wrongly stored would push every later pair out of order, so the check fails on the next drained pair.

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        cfg_enable,
  input  logic        cfg_compact,
  input  logic [1:0]  cfg_size,
  input  logic [1:0]  cfg_slot_sel,
  input  logic        cdc_ready,
  output logic        cdc_valid,
  output logic [19:0] cdc_left,
  output logic [19:0] cdc_right,
  output logic        st_empty,
  output logic        st_half,
  output logic        st_full,
  output logic        st_underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 2;
  localparam logic [LW-1:0] FULL_L = LW'(DEPTH);
  localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);
  localparam logic [LW-1:0] TWO_L  = LW'(2);

  logic [19:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] lvl, lvl_n, n_push, n_pop;
  logic          burst;

  logic          packed2, ok_one, ok_two, pop;
  logic [19:0]   s_one, s_lo, s_hi;
  logic [3:0]    c_sh;

  assign packed2 = cfg_compact & (cfg_size[0] == cfg_size[1]);
  assign c_sh    = (cfg_size == 2'd3) ? 4'd8 : 4'd4;
  assign s_lo    = {4'b0, wr_data[15:0]} << c_sh;
  assign s_hi    = {4'b0, wr_data[31:16]} << c_sh;

  always_comb begin
    case (cfg_size)
      2'd0:    s_one = wr_data[19:0] << 4;
      2'd1:    s_one = wr_data[19:0] << 2;
      2'd2:    s_one = wr_data[19:0];
      default: s_one = wr_data[19:0] << 8;
    endcase
  end

  assign ok_one = wr_en & ~packed2 & (lvl < FULL_L);
  assign ok_two = wr_en &  packed2 & ((lvl + TWO_L) < FULL_L);

  assign cdc_valid = cfg_enable & (|cfg_slot_sel) & (lvl >= TWO_L) &
                     ((lvl >= HALF_L) | burst);
  assign pop       = cdc_valid & cdc_ready;
  assign cdc_left  = mem[rp];
  assign cdc_right = mem[rp + AW'(1)];

  assign n_push = ok_two ? TWO_L : (ok_one ? LW'(1) : '0);
  assign n_pop  = pop ? TWO_L : '0;
  assign lvl_n  = lvl + n_push - n_pop;

  always_ff @(posedge clk) begin
    if (ok_one) mem[wp] <= s_one;
    if (ok_two) begin
      mem[wp]          <= s_lo;
      mem[wp + AW'(1)] <= s_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      lvl   <= '0;
      burst <= 1'b0;
    end else begin
      if (ok_one) wp <= wp + AW'(1);
      if (ok_two) wp <= wp + AW'(2);
      if (pop)    rp <= rp + AW'(2);
      lvl   <= lvl_n;
      burst <= pop & (lvl_n >= TWO_L);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_empty    <= 1'b1;
      st_half     <= 1'b1;
      st_full     <= 1'b0;
      st_underrun <= 1'b0;
    end else begin
      if (wr_en) begin
        if (lvl_n != '0) begin
          st_empty    <= 1'b0;
          st_underrun <= 1'b0;
        end
        if (lvl_n >= HALF_L) st_half <= 1'b0;
        if (lvl_n >= FULL_L) st_full <= 1'b1;
      end
      if (pop) begin
        st_full <= 1'b0;
        if (lvl_n <= HALF_L) st_half <= 1'b1;
        if (lvl_n == '0) begin
          st_empty    <= 1'b1;
          st_underrun <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int LW = $clog2(DEPTH) + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          cfg_enable,
  input logic [1:0]    cfg_slot_sel,
  input logic          cdc_ready,
  input logic          cdc_valid,
  input logic          st_empty,
  input logic          st_full,
  input logic          st_underrun,
  input logic [LW-1:0] lvl
);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LW'(DEPTH));

  assert_full_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_full && st_empty));

  assert_valid_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_valid |-> (cfg_enable && (cfg_slot_sel != 2'b00)));

  assert_valid_has_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_valid |-> (lvl >= LW'(2)));

  assert_empty_means_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty |-> (lvl == '0));

  assert_underrun_in_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_underrun |-> st_empty);

  assert_pop_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cdc_valid && cdc_ready && !wr_en) |=> (lvl == $past(lvl) - LW'(2)));
endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_enable(cfg_enable),
  .cfg_slot_sel(cfg_slot_sel), .cdc_ready(cdc_ready), .cdc_valid(cdc_valid),
  .st_empty(st_empty), .st_full(st_full), .st_underrun(st_underrun), .lvl(lvl)
);

// File: tb/sim_audio_tx_fifo.sv
`timescale 1ns/1ps
module sim_audio_tx_fifo;
  localparam int D = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, cfg_enable = 1'b0, cfg_compact = 1'b0, cdc_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0] cfg_size = 2'd0, cfg_slot_sel = 2'b01;
  logic cdc_valid, st_empty, st_half, st_full, st_underrun;
  logic [19:0] cdc_left, cdc_right;

  int n_chk = 0, n_fail = 0, sz;
  int mq[$];
  bit comp;

  always #5 clk = ~clk;

  audio_tx_fifo #(.DEPTH(D)) u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] pk_one(logic [31:0] w, logic [1:0] s);
    logic [31:0] r;
    case (s)
      2'd0: r = w * 16;
      2'd1: r = w * 4;
      2'd2: r = w;
      default: r = w * 256;
    endcase
    return r[19:0];
  endfunction

  function automatic logic [19:0] pk_half(logic [15:0] h, logic [1:0] s);
    logic [31:0] r;
    r = (s == 2'd3) ? ({16'b0, h} * 256) : ({16'b0, h} * 16);
    return r[19:0];
  endfunction

  // Reference queue: follows every write and every transferred pair.
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      sz = mq.size();
      if (wr_en) begin
        comp = cfg_compact && (cfg_size == 2'd0 || cfg_size == 2'd3);
        if (comp) begin
          if (sz + 2 < D) begin
            mq.push_back(int'(pk_half(wr_data[15:0], cfg_size)));
            mq.push_back(int'(pk_half(wr_data[31:16], cfg_size)));
          end
        end else if (sz < D) begin
          mq.push_back(int'(pk_one(wr_data, cfg_size)));
        end
      end
      if (cdc_valid && cdc_ready) begin
        if (sz < 2) chk("R7 pair offered with under two samples", 32'(sz), 32'd2);
        else begin
          chk("R6/R2/R3 left sample", {12'b0, cdc_left}, 32'(mq[0]));
          chk("R6/R2/R3 right sample", {12'b0, cdc_right}, 32'(mq[1]));
          void'(mq.pop_front());
          void'(mq.pop_front());
        end
      end
    end
  end

  task automatic wr(input logic [31:0] w);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1
    chk("R1 empty", st_empty, 1);
    chk("R1 half", st_half, 1);
    chk("R1 full", st_full, 0);
    chk("R1 underrun", st_underrun, 0);
    chk("R1 valid", cdc_valid, 0);

    // R2, R4, R5, R8: normal mode for every size code
    cdc_ready = 1'b1;
    for (int s = 0; s < 4; s++) begin
      cfg_size = 2'(s);
      cfg_compact = 1'b0;
      cfg_enable = 1'b0;
      for (int i = 0; i < D; i++) begin
        wr(32'hF9AB_C5D3 ^ (32'(i) * 32'h0103_0507) ^ 32'(s));
        chk("R5 empty cleared", st_empty, 0);
        chk("R5 half", st_half, 32'(i + 1 < D / 2));
        chk("R5 full", st_full, 32'(i + 1 == D));
      end
      chk("R6 no drain while disabled", cdc_valid, 0);
      wr(32'h000F_FFFF);
      chk("R4 full held after drop", st_full, 1);
      cfg_enable = 1'b1;
      idle(1);
      chk("R8 full cleared on drain", st_full, 0);
      chk("R8 half stays clear above half", st_half, 0);
      idle(5);
      chk("R8 empty after drain", st_empty, 1);
      chk("R8 underrun after drain", st_underrun, 1);
      chk("R8 half after drain", st_half, 1);
      chk("R2 all samples drained", 32'(mq.size()), 0);
      cfg_enable = 1'b0;
    end

    // R3, R4: compact packing for 16 and 12 bit codes
    for (int k = 0; k < 2; k++) begin
      cfg_size = (k == 0) ? 2'd0 : 2'd3;
      cfg_compact = 1'b1;
      for (int i = 0; i < 4; i++) wr(32'h8D2C_7B1E + 32'(i) * 32'h1111_2222);
      chk("R4 compact drop keeps full clear", st_full, 0);
      chk("R5 half cleared at six", st_half, 0);
      chk("R3 model level six", 32'(mq.size()), 6);
      cfg_enable = 1'b1;
      idle(5);
      chk("R3 compact drained", st_empty, 1);
      chk("R3 queue empty", 32'(mq.size()), 0);
      cfg_enable = 1'b0;
    end

    // R3: compact ignored for 18-bit
    cfg_size = 2'd1;
    cfg_compact = 1'b1;
    for (int i = 0; i < 3; i++) wr(32'hABCD_0123 + 32'(i));
    chk("R3 compact ignored, half still set at three", st_half, 1);
    wr(32'h0004_5678);
    chk("R3 compact ignored, half clear at four", st_half, 0);
    cfg_enable = 1'b1;
    idle(4);
    chk("R3 ignored-mode drained", st_empty, 1);
    cfg_enable = 1'b0;
    cfg_compact = 1'b0;

    // R6, R7, R8: codec refusal
    cfg_size = 2'd2;
    for (int i = 0; i < D; i++) wr(32'h0003_0000 + 32'(i) * 32'h0000_1011);
    cdc_ready = 1'b0;
    cfg_enable = 1'b1;
    idle(1);
    chk("R6 valid when full and enabled", cdc_valid, 1);
    chk("R6 oldest sample left", {12'b0, cdc_left}, 32'h0003_0000);
    chk("R6 next sample right", {12'b0, cdc_right}, 32'h0003_1011);
    cdc_ready = 1'b1; idle(1); cdc_ready = 1'b0;
    chk("R7 valid at six", cdc_valid, 1);
    chk("R8 full cleared", st_full, 0);
    chk("R8 half clear at six", st_half, 0);
    cdc_ready = 1'b1; idle(1); cdc_ready = 1'b0;
    chk("R7 valid at four", cdc_valid, 1);
    chk("R8 half set at four", st_half, 1);
    cdc_ready = 1'b1; idle(1); cdc_ready = 1'b0;
    chk("R7 burst continues at two", cdc_valid, 1);
    idle(1);
    chk("R7 burst ends after refusal", cdc_valid, 0);
    chk("R8 not empty at two", st_empty, 0);
    chk("R8 no underrun at two", st_underrun, 0);

    // R6: slot selection
    cfg_slot_sel = 2'b00;
    cdc_ready = 1'b1;
    wr(32'h0000_0AAA);
    wr(32'h0000_0BBB);
    chk("R6 no slot selected", cdc_valid, 0);
    cfg_slot_sel = 2'b10;
    idle(4);
    chk("R6 slot 4 drains", st_empty, 1);
    chk("R6 queue empty", 32'(mq.size()), 0);
    cfg_slot_sel = 2'b01;

    // R9: writes every cycle while draining
    for (int i = 0; i < 40; i++) wr(32'(i + 1));
    idle(8);
    chk("R9 residue below two", 32'(mq.size() < 2), 1);
    chk("R9 empty matches residue", st_empty, 32'(mq.size() == 0));

    summary();
  end
endmodule